// File: doc/BRIEF.md
# ADC Oversampling Accumulator

This block sits between an analog-to-digital converter's result port and the data registers that hold finished samples. While oversampling is enabled, it adds up a programmable power-of-two number of consecutive conversions of one channel. It then shifts the total right by a programmable amount and presents the outcome as a single 16-bit sample with a one-cycle valid strobe. While oversampling is disabled, each raw 12-bit result goes straight to the output, one cycle after it arrives.

The block also paces the converter through a request output. The trigger mode has two settings. In burst mode, one trigger starts the whole set of sub-conversions and each accepted result requests the next. In per-trigger mode, every sub-conversion needs its own trigger. Ratio and shift are independent settings, so the output can be a plain sum, a true average or anything in between. A final alignment stage chooses between a right-justified word and a left-justified 12-bit field.

Top module: `adc_ovs_accum`

## Requirements
- R1: While reset is asserted and on the first cycle after it, conv_req_o and res_valid_o are 0 and res_data_o is 0.
- R2: With ovs_en_i low, every raw_valid_i produces res_valid_o high for exactly the next cycle, and res_data_o carries raw_data_i zero-extended in bits 11:0 when align_left_i is 0.
- R3: With ovs_en_i high, ratio code n on ratio_sel_i (0 to 7) collects 2^(n+1) samples. res_valid_o stays low on all other samples and pulses for one cycle, the cycle after the last sample is accepted. res_data_o is then the sum of those samples shifted right by the shift setting, truncated to its low 16 bits.
- R4: shift_i values 0 to 8 give that many bits of right shift; any code above 8 behaves as 8.
- R5: The running sum never wraps: 256 samples of 4095 give 1048320 before the shift (4095 with shift 8, 65520 with shift 4, 65280 with shift 0 after truncation).
- R6: With trig_each_i = 0 (burst), a trigger while no conversion is outstanding makes conv_req_o pulse on the next cycle. Each accepted sample that is not the last of its set makes conv_req_o pulse on the next cycle. After the last sample, no request follows.
- R7: With trig_each_i = 1, conv_req_o only pulses on the cycle after an accepted trigger; accepted samples never raise it.
- R8: A trigger that arrives after a request was issued and before the matching raw_valid_i is ignored: conv_req_o stays 0 on the next cycle.
- R9: With align_left_i = 1, res_data_o bits 15:4 hold the low 12 bits of the result and bits 3:0 are 0.
- R10: A change on chan_i with no sample in that cycle discards the partial sum and count; the next set starts from zero.
- R11: Dropping ovs_en_i for a cycle discards the partial sum and count; after re-enabling, the next set starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ovs_en_i | input | 1 | Oversampling enable; low means pass-through |
| ratio_sel_i | input | 3 | Ratio code n, 2^(n+1) samples per output |
| shift_i | input | 4 | Right shift of the sum, 0 to 8 (larger codes act as 8) |
| trig_each_i | input | 1 | 0: burst after one trigger, 1: one trigger per sub-conversion |
| align_left_i | input | 1 | 1: left-justify the 12-bit result in the 16-bit word |
| chan_i | input | 5 | Channel currently converted |
| trig_i | input | 1 | Conversion trigger strobe |
| raw_valid_i | input | 1 | Raw result strobe from the converter |
| raw_data_i | input | 12 | Raw conversion result |
| conv_req_o | output | 1 | One-cycle request to start the next conversion |
| res_valid_o | output | 1 | One-cycle strobe for a finished output sample |
| res_data_o | output | 16 | Finished output sample |

## Verification
Four properties are checked on every cycle. A trigger during an outstanding conversion never yields a request. Per-trigger mode never raises a request by itself. Two oversampled outputs never come back to back, and a left-justified word always has zero low bits. The accumulator's carry out is also checked on every cycle and must never be set. The numeric content of each result needs the bench's scenarios: the sum over a ratio, shift clamping, saturating inputs at ratio 256, and the discarding of partial sums on a channel change or a disable. The bench compares these against sums it computes itself.

// File: rtl/adc_ovs_pkg.sv
package adc_ovs_pkg;
  localparam int RAW_W     = 12;
  localparam int OUT_W     = 16;
  localparam int RSEL_W    = 3;
  localparam int SHIFT_W   = 4;
  localparam int MAX_SHIFT = 8;
  localparam int CH_W      = 5;

  typedef enum logic {
    TRIG_BURST = 1'b0,
    TRIG_EACH  = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/adc_ovs_seq.sv
module adc_ovs_seq
  import adc_ovs_pkg::*;
#(
  parameter int CH_W   = 5,
  parameter int RSEL_W = 3,
  parameter int CNT_W  = 1 << RSEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ovs_en_i,
  input  logic              trig_each_i,
  input  logic [RSEL_W-1:0] ratio_sel_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              trig_i,
  input  logic              raw_valid_i,
  output logic              conv_req_o,
  output logic              last_o,
  output logic              clear_o
);
  logic             req_q, req_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CH_W-1:0]  chan_q;
  logic [CNT_W-1:0] last_idx;
  logic             chan_chg, burst_mode;

  always_comb begin
    burst_mode = (trig_mode_e'(trig_each_i) == TRIG_BURST);
    chan_chg   = (chan_i != chan_q);
    clear_o    = !ovs_en_i || chan_chg;
    last_idx   = (CNT_W'(2) << ratio_sel_i) - CNT_W'(1);
    last_o     = !clear_o && raw_valid_i && (cnt_q >= last_idx);
    req_d      = (trig_i && !pend_q) ||
                 (!clear_o && burst_mode && raw_valid_i && !last_o);
    if (req_d)            pend_d = 1'b1;
    else if (raw_valid_i) pend_d = 1'b0;
    else                  pend_d = pend_q;
    if (clear_o)          cnt_d = '0;
    else if (raw_valid_i) cnt_d = last_o ? '0 : cnt_q + CNT_W'(1);
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      chan_q <= '0;
    end else begin
      req_q  <= req_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      chan_q <= chan_i;
    end
  end

  assign conv_req_o = req_q;

  AST_NO_REQ_WHILE_WAITING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !raw_valid_i) |=> !conv_req_o);  // R8
  AST_EACH_NO_AUTO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_each_i && !trig_i) |=> !conv_req_o);  // R7
endmodule

// File: rtl/adc_ovs_acc.sv
module adc_ovs_acc #(
  parameter int RAW_W = 12,
  parameter int ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             raw_valid_i,
  input  logic             last_i,
  input  logic [RAW_W-1:0] raw_data_i,
  output logic [ACC_W-1:0] sum_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   wide_sum;
  logic             add_en;

  always_comb begin
    wide_sum = {1'b0, acc_q} + {{(ACC_W + 1 - RAW_W){1'b0}}, raw_data_i};
    sum_o    = wide_sum[ACC_W-1:0];
    add_en   = raw_valid_i && !clear_i;
    if (clear_i)     acc_d = '0;
    else if (add_en) acc_d = last_i ? '0 : sum_o;
    else             acc_d = acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_en |-> !wide_sum[ACC_W]);  // R5
endmodule

// File: rtl/adc_ovs_fmt.sv
module adc_ovs_fmt #(
  parameter int RAW_W     = 12,
  parameter int OUT_W     = 16,
  parameter int ACC_W     = 20,
  parameter int SHIFT_W   = 4,
  parameter int MAX_SHIFT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ovs_en_i,
  input  logic               raw_valid_i,
  input  logic               last_i,
  input  logic               align_left_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [RAW_W-1:0]   raw_data_i,
  input  logic [ACC_W-1:0]   sum_i,
  output logic               res_valid_o,
  output logic [OUT_W-1:0]   res_data_o
);
  localparam int PAD_W = OUT_W - RAW_W;

  logic [SHIFT_W-1:0] shift_eff;
  logic [OUT_W-1:0]   value, word_d, data_q;
  logic               valid_d, valid_q;

  always_comb begin
    shift_eff = (shift_i > SHIFT_W'(MAX_SHIFT)) ? SHIFT_W'(MAX_SHIFT) : shift_i;
    if (ovs_en_i) value = OUT_W'(sum_i >> shift_eff);
    else          value = {{PAD_W{1'b0}}, raw_data_i};
    word_d  = align_left_i ? {value[RAW_W-1:0], {PAD_W{1'b0}}} : value;
    valid_d = ovs_en_i ? last_i : raw_valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (valid_d) data_q <= word_d;
    end
  end

  assign res_valid_o = valid_q;
  assign res_data_o  = data_q;

  AST_OVS_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovs_en_i && $past(ovs_en_i) && res_valid_o) |=> !res_valid_o);  // R3
  AST_LEFT_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_d && align_left_i) |=> (res_data_o[PAD_W-1:0] == '0));  // R9
endmodule

// File: rtl/adc_ovs_accum.sv
module adc_ovs_accum
  import adc_ovs_pkg::*;
#(
  parameter int P_RAW_W     = RAW_W,
  parameter int P_OUT_W     = OUT_W,
  parameter int P_RSEL_W    = RSEL_W,
  parameter int P_SHIFT_W   = SHIFT_W,
  parameter int P_MAX_SHIFT = MAX_SHIFT,
  parameter int P_CH_W      = CH_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ovs_en_i,
  input  logic [P_RSEL_W-1:0]  ratio_sel_i,
  input  logic [P_SHIFT_W-1:0] shift_i,
  input  logic                 trig_each_i,
  input  logic                 align_left_i,
  input  logic [P_CH_W-1:0]    chan_i,
  input  logic                 trig_i,
  input  logic                 raw_valid_i,
  input  logic [P_RAW_W-1:0]   raw_data_i,
  output logic                 conv_req_o,
  output logic                 res_valid_o,
  output logic [P_OUT_W-1:0]   res_data_o
);
  localparam int CNT_W = 1 << P_RSEL_W;
  localparam int ACC_W = P_RAW_W + CNT_W;

  logic             last_s, clear_s;
  logic [ACC_W-1:0] sum_s;

  adc_ovs_seq #(.CH_W(P_CH_W), .RSEL_W(P_RSEL_W), .CNT_W(CNT_W)) seq_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ovs_en_i(ovs_en_i),
    .trig_each_i(trig_each_i), .ratio_sel_i(ratio_sel_i), .chan_i(chan_i),
    .trig_i(trig_i), .raw_valid_i(raw_valid_i), .conv_req_o(conv_req_o),
    .last_o(last_s), .clear_o(clear_s)
  );

  adc_ovs_acc #(.RAW_W(P_RAW_W), .ACC_W(ACC_W)) acc_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_s),
    .raw_valid_i(raw_valid_i), .last_i(last_s), .raw_data_i(raw_data_i),
    .sum_o(sum_s)
  );

  adc_ovs_fmt #(.RAW_W(P_RAW_W), .OUT_W(P_OUT_W), .ACC_W(ACC_W),
                .SHIFT_W(P_SHIFT_W), .MAX_SHIFT(P_MAX_SHIFT)) fmt_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ovs_en_i(ovs_en_i),
    .raw_valid_i(raw_valid_i), .last_i(last_s), .align_left_i(align_left_i),
    .shift_i(shift_i), .raw_data_i(raw_data_i), .sum_i(sum_s),
    .res_valid_o(res_valid_o), .res_data_o(res_data_o)
  );
endmodule

// File: tb/adc_ovs_accum_tb.sv
module adc_ovs_accum_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ovs_en, trig_each, align_left, trig, raw_valid;
  logic [2:0]  ratio_sel;
  logic [3:0]  shift;
  logic [4:0]  chan;
  logic [11:0] raw_data;
  logic        conv_req, res_valid;
  logic [15:0] res_data;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  adc_ovs_accum dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ovs_en_i(ovs_en), .ratio_sel_i(ratio_sel),
    .shift_i(shift), .trig_each_i(trig_each), .align_left_i(align_left),
    .chan_i(chan), .trig_i(trig), .raw_valid_i(raw_valid), .raw_data_i(raw_data),
    .conv_req_o(conv_req), .res_valid_o(res_valid), .res_data_o(res_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_word(input int sum, input int sh, input bit left);
    int s = (sh > 8) ? 8 : sh;
    int v = (sum >> s) & 16'hFFFF;
    return left ? ((v & 12'hFFF) << 4) : v;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_trig();
    trig = 1'b1; tick(); trig = 1'b0;
  endtask

  task automatic give_sample(input logic [11:0] v);
    raw_valid = 1'b1; raw_data = v; tick(); raw_valid = 1'b0;
  endtask

  task automatic do_run(input int sel, input int sh, input bit left,
                        input bit each, input bit allmax, input string tag);
    int n = 2 << sel;
    int sum = 0;
    ratio_sel = 3'(sel); shift = 4'(sh); align_left = left; trig_each = each;
    ovs_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic [11:0] v = allmax ? 12'hFFF : 12'($urandom_range(4095));
      if (i == 0 || each) pulse_trig();
      check(conv_req == 1'b1, each ? "R7 request" : "R6 request", conv_req, 1);
      repeat ($urandom_range(2)) tick();
      give_sample(v);
      sum += v;
      if (i == n - 1) begin
        check(res_valid == 1'b1, "R3 valid", res_valid, 1);
        check(res_data == 16'(exp_word(sum, sh, left)), tag, res_data, exp_word(sum, sh, left));
        check(conv_req == 1'b0, "R6 no request after last", conv_req, 0);
        tick();
        check(res_valid == 1'b0, "R3 single pulse", res_valid, 0);
      end else begin
        check(res_valid == 1'b0, "R3 no early valid", res_valid, 0);
        if (each) check(conv_req == 1'b0, "R7 no auto request", conv_req, 0);
      end
    end
  endtask

  task automatic partial(input int k);
    trig_each = 1'b1; ratio_sel = 3'd1; ovs_en = 1'b1;
    for (int i = 0; i < k; i++) begin
      pulse_trig();
      give_sample(12'hABC);
      check(res_valid == 1'b0, "R3 partial no valid", res_valid, 0);
    end
  endtask

  task automatic pass_one(input logic [11:0] v, input bit left);
    ovs_en = 1'b0; align_left = left;
    pulse_trig();
    give_sample(v);
    check(res_valid == 1'b1, "R2 valid", res_valid, 1);
    check(res_data == (left ? {v, 4'b0} : {4'b0, v}), left ? "R9 left pass" : "R2 data",
          res_data, left ? {v, 4'b0} : {4'b0, v});
    tick();
    check(res_valid == 1'b0, "R2 single pulse", res_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ovs_en = 1'b0; trig_each = 1'b0; align_left = 1'b0; trig = 1'b0;
    raw_valid = 1'b0; ratio_sel = '0; shift = '0; chan = 5'd3; raw_data = '0;
    repeat (3) tick();
    check(conv_req == 1'b0 && res_valid == 1'b0, "R1 reset strobes", {conv_req, res_valid}, 0);
    check(res_data == 16'd0, "R1 reset data", res_data, 0);
    rst_n = 1'b1;
    tick();
    check(conv_req == 1'b0 && res_valid == 1'b0 && res_data == 16'd0, "R1 after release",
          res_data, 0);

    pass_one(12'h5A3, 1'b0);
    pass_one(12'hFFF, 1'b0);
    pass_one(12'h123, 1'b1);

    // R8: second trigger while waiting is ignored
    ovs_en = 1'b0; trig_each = 1'b1;
    pulse_trig();
    check(conv_req == 1'b1, "R8 first request", conv_req, 1);
    pulse_trig();
    check(conv_req == 1'b0, "R8 trigger ignored", conv_req, 0);
    give_sample(12'h001);
    tick();

    do_run(7, 0, 1'b0, 1'b0, 1'b1, "R5 sum shift0");
    do_run(7, 4, 1'b0, 1'b1, 1'b1, "R5 sum shift4");
    do_run(7, 8, 1'b0, 1'b0, 1'b1, "R5 sum shift8");
    do_run(2, 13, 1'b0, 1'b0, 1'b0, "R4 shift clamp");
    do_run(0, 0, 1'b1, 1'b1, 1'b0, "R9 left ovs");

    partial(2);
    chan = chan + 5'd1;
    tick();
    do_run(1, 0, 1'b0, 1'b1, 1'b0, "R10 channel clear");

    partial(3);
    ovs_en = 1'b0;
    tick();
    do_run(1, 1, 1'b0, 1'b0, 1'b0, "R11 disable clear");

    for (int r = 0; r < 24; r++) begin
      do_run($urandom_range(4), $urandom_range(8), 1'($urandom_range(1)),
             1'($urandom_range(1)), 1'b0, "R3 random data");
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule